// File: doc/BRIEF.md
# Free-Running Timer with Capture/Compare Option Register

The block is an up-counting timer with two channel registers and an 8-bit option register. While the timer is enabled, the counter advances once for each count-enable tick. Each channel register can act as a compare register or as a capture register. A compare channel pulses its match output when a tick arrives while the counter equals the stored value. A capture channel latches the counter on a rising edge of its capture input. The option register holds two role-select bits, one per channel, and a sticky overflow flag. The flag, together with a one-cycle interrupt pulse, reports the counter wrapping from all ones to zero.

Software reaches the block over a simple synchronous register bus. The bus offers full-width writes and single-bit writes, and reads are combinational. The control register holds an enable bit and a 3-bit mode field. Only the free-running and pulse-width modes are modelled in full. The other mode codes are recognised only to suppress overflow detection and to force both channels into the compare role.

Top module: `fr_timer_opt`

## Requirements
- R1: After reset, every register reads 0 and match_o and ovf_irq_o are low. The register map is: control at address 0 (bit 7 enable, bits 2:0 mode), counter read-back at address 2, option at address 5, channel 0 at address 8 and channel 1 at address 10. Any other address reads 0.
- R2: While enable is 1, the counter adds 1 at every clock edge where tick_i is 1 and otherwise holds its value. While enable is 0, the counter is 0.
- R3: The overflow flag (option bit 0) is set by an edge where the counter is all ones, tick_i is 1, enable is 1 and the mode is free-running (1) or pulse-width (2). ovf_irq_o is high for exactly the one cycle in which the flag first reads 1 after that edge. In every other mode, neither the flag nor the pulse ever appears.
- R4: The overflow flag is cleared by a write of 0 to option bit 0, by a byte write or a single-bit write. It is also cleared at any edge where enable is 0.
- R5: Writing 1 to option bit 0 leaves the flag unchanged. Reading the option register, any number of times, does not clear the flag.
- R6: Option bits 7, 6, 3, 2 and 1 always read 0, whatever value is written.
- R7: Option bits 4 (channel 0) and 5 (channel 1) select the role: 1 is capture and 0 is compare. They take any written value while enable is 0. While enable is 1, a write of the stored value is accepted and a write of a different value is ignored.
- R8: The role bits take effect only in free-running mode. In any other mode, both channels act as compare registers, and a capture edge does not change them.
- R9: A capture-role channel loads the counter's current value at a clock edge where enable is 1, its cap_i is 1 and cap_i was 0 at the previous edge. Holding cap_i high captures only once.
- R10: In the compare role, when tick_i is 1 at an edge where the counter equals the channel value, that channel's match_o is high for the following cycle only.
- R11: If a software clear of the overflow flag and a new overflow happen at the same edge, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable tick |
| cap_i | input | 2 | Capture trigger inputs, one per channel |
| bus_wr_i | input | 1 | Full-width write strobe |
| bus_bit_wr_i | input | 1 | Single-bit write strobe (control and option registers only) |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | CNT_W | Write data for full-width writes |
| bus_bit_sel_i | input | 3 | Bit index for single-bit writes |
| bus_bit_val_i | input | 1 | Bit value for single-bit writes |
| bus_rdata_o | output | CNT_W | Combinational read data for bus_addr_i |
| match_o | output | 2 | Compare-match pulses, one per channel |
| ovf_irq_o | output | 1 | Overflow interrupt pulse |

## Verification
The bench builds the block with CNT_W set to 8, so the counter wraps every 256 ticks. This makes it practical to cause many overflows in one run. It also makes it possible to land a software clear exactly on the wrap edge, and to test overflow suppression in the modes that have none. The same width lets compare matches and captures fall at counter values the bench can predict from its own model. Tick spacing of one tick every cycle, one every three cycles, and no ticks at all covers both counting and holding.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [2:0] {
    MODE_INTERVAL = 3'd0,
    MODE_FREE     = 3'd1,
    MODE_PWIDTH   = 3'd2,
    MODE_ONESHOT  = 3'd3,
    MODE_EVENT    = 3'd4,
    MODE_PWM      = 3'd5,
    MODE_SPARE6   = 3'd6,
    MODE_SPARE7   = 3'd7
  } mode_e;

  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned OVF_BIT  = 0;
  localparam int unsigned ROLE_LSB = 4;
  localparam int unsigned EN_BIT   = 7;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_OPT  = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_CH0  = 4'd8;

  // masked write request into an 8-bit register
  typedef struct packed {
    logic       valid;
    logic [7:0] mask;
    logic [7:0] data;
  } wr8_t;
endpackage

// File: rtl/frt_counter.sv
module frt_counter
  import frt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  mode_e            mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_mode;

  assign ovf_mode  = (mode_i == MODE_FREE) || (mode_i == MODE_PWIDTH);
  assign ovf_evt_o = en_i && tick_i && (&cnt_q) && ovf_mode;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/frt_regs.sv
module frt_regs
  import frt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr8_t              ctrl_wr_i,
  input  wr8_t              opt_wr_i,
  input  logic              ovf_evt_i,
  output logic              en_o,
  output mode_e             mode_o,
  output logic [NUM_CH-1:0] role_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic              en_q;
  logic [2:0]        mode_q;
  logic [NUM_CH-1:0] role_q;
  logic              ovf_q;
  logic              irq_q;
  logic              ovf_clr;

  assign ovf_clr = opt_wr_i.valid && opt_wr_i.mask[OVF_BIT] && !opt_wr_i.data[OVF_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= '0;
    end else if (ctrl_wr_i.valid) begin
      if (ctrl_wr_i.mask[EN_BIT]) en_q <= ctrl_wr_i.data[EN_BIT];
      for (int i = 0; i < 3; i++)
        if (ctrl_wr_i.mask[i]) mode_q[i] <= ctrl_wr_i.data[i];
    end
  end

  // role bits locked while running unless the write repeats the stored value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) role_q <= '0;
    else if (opt_wr_i.valid) begin
      for (int k = 0; k < NUM_CH; k++)
        if (opt_wr_i.mask[ROLE_LSB+k] &&
            (!en_q || (opt_wr_i.data[ROLE_LSB+k] == role_q[k])))
          role_q[k] <= opt_wr_i.data[ROLE_LSB+k];
    end
  end

  // overflow beats a same-edge software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= ovf_evt_i;
      if (!en_q)          ovf_q <= 1'b0;
      else if (ovf_evt_i) ovf_q <= 1'b1;
      else if (ovf_clr)   ovf_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_e'(mode_q);
  assign role_o = role_q;
  assign ovf_o  = ovf_q;
  assign irq_o  = irq_q;

  assert_irq_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ovf_q);
  assert_dis_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !ovf_q);
  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && en_q && !ovf_clr |=> ovf_q);
  assert_role_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(role_q));
  assert_ovf_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_q);
endmodule

// File: rtl/frt_chan.sv
module frt_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cap_role_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] val_o,
  output logic             match_o
);
  logic [CNT_W-1:0] val_q;
  logic             cap_prev_q;
  logic             match_q;
  logic             fire;

  assign fire = en_i && cap_role_i && cap_i && !cap_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q      <= '0;
      cap_prev_q <= 1'b0;
      match_q    <= 1'b0;
    end else begin
      cap_prev_q <= cap_i;
      match_q    <= en_i && !cap_role_i && tick_i && (cnt_i == val_q);
      if (fire)      val_q <= cnt_i;
      else if (wr_i) val_q <= wdata_i;
    end
  end

  assign val_o   = val_q;
  assign match_o = match_q;

  assert_cap_nomatch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_role_i |=> !match_q);
  assert_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (val_q == $past(cnt_i)));
  assert_match_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |=> !match_q);
endmodule

// File: rtl/fr_timer_opt.sv
module fr_timer_opt
  import frt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [NUM_CH-1:0]  cap_i,
  input  logic               bus_wr_i,
  input  logic               bus_bit_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [CNT_W-1:0]   bus_wdata_i,
  input  logic [2:0]         bus_bit_sel_i,
  input  logic               bus_bit_val_i,
  output logic [CNT_W-1:0]   bus_rdata_o,
  output logic [NUM_CH-1:0]  match_o,
  output logic               ovf_irq_o
);
  wr8_t              ctrl_wr, opt_wr;
  logic [7:0]        wr_mask, wr_data;
  logic              en;
  mode_e             mode;
  logic [NUM_CH-1:0] role;
  logic [NUM_CH-1:0] eff_cap;
  logic              ovf;
  logic              ovf_evt;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  ch_val [NUM_CH];

  assign wr_mask = bus_wr_i ? 8'hFF : (8'd1 << bus_bit_sel_i);
  assign wr_data = bus_wr_i ? bus_wdata_i[7:0] : {8{bus_bit_val_i}};

  assign ctrl_wr = '{valid: (bus_wr_i || bus_bit_wr_i) && (bus_addr_i == ADDR_CTRL),
                     mask: wr_mask, data: wr_data};
  assign opt_wr  = '{valid: (bus_wr_i || bus_bit_wr_i) && (bus_addr_i == ADDR_OPT),
                     mask: wr_mask, data: wr_data};

  frt_regs u_regs (
    .clk_i, .rst_ni,
    .ctrl_wr_i (ctrl_wr),
    .opt_wr_i  (opt_wr),
    .ovf_evt_i (ovf_evt),
    .en_o      (en),
    .mode_o    (mode),
    .role_o    (role),
    .ovf_o     (ovf),
    .irq_o     (ovf_irq_o)
  );

  frt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i      (en),
    .tick_i    (tick_i),
    .mode_i    (mode),
    .cnt_o     (cnt),
    .ovf_evt_o (ovf_evt)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_CH0 + ADDR_W'(2 * k);
    assign eff_cap[k] = (mode == MODE_FREE) && role[k];
    frt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i, .rst_ni,
      .en_i       (en),
      .cap_role_i (eff_cap[k]),
      .tick_i     (tick_i),
      .cnt_i      (cnt),
      .cap_i      (cap_i[k]),
      .wr_i       (bus_wr_i && (bus_addr_i == CH_ADDR)),
      .wdata_i    (bus_wdata_i),
      .val_o      (ch_val[k]),
      .match_o    (match_o[k])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_CTRL) bus_rdata_o[7:0] = {en, 4'b0000, mode};
    if (bus_addr_i == ADDR_CNT)  bus_rdata_o = cnt;
    if (bus_addr_i == ADDR_OPT)  bus_rdata_o[7:0] = {2'b00, role, 3'b000, ovf};
    for (int k = 0; k < NUM_CH; k++)
      if (bus_addr_i == ADDR_CH0 + ADDR_W'(2 * k)) bus_rdata_o = ch_val[k];
  end

  assert_irq_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> ($past(mode) == MODE_FREE) || ($past(mode) == MODE_PWIDTH));
  assert_ovf_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> (cnt == '0));
endmodule

// File: tb/sim_fr_timer_opt.sv
`timescale 1ns/1ps
module sim_fr_timer_opt;
  localparam int W = 8;
  localparam logic [W-1:0] MAXV = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         tick = 1'b0;
  logic [1:0]   cap = '0;
  logic         bwr = 1'b0, bbit = 1'b0, bval = 1'b0;
  logic [3:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [2:0]   bsel = '0;
  logic [W-1:0] rdata;
  logic [1:0]   match;
  logic         irq;

  fr_timer_opt #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cap_i(cap),
    .bus_wr_i(bwr), .bus_bit_wr_i(bbit), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_bit_sel_i(bsel), .bus_bit_val_i(bval), .bus_rdata_o(rdata),
    .match_o(match), .ovf_irq_o(irq)
  );

  int tests = 0, fails = 0, cyc = 0, tick_div = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 tick = (tick_div == 1) || (tick_div > 1 && (cyc % tick_div) == 0);
  end

  // reference model
  bit         m_en, m_ovf, m_irq;
  int         m_mode;
  bit [1:0]   m_role, m_prev, m_match;
  int         m_cnt;
  int         m_ch [2];

  function automatic int mrd(int a);
    case (a)
      0:  return (m_en ? 128 : 0) + m_mode;
      2:  return m_cnt;
      5:  return m_role * 16 + (m_ovf ? 1 : 0);
      8:  return m_ch[0];
      10: return m_ch[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ovf = 0; m_irq = 0; m_mode = 0; m_role = 0; m_prev = 0;
      m_match = 0; m_cnt = 0; m_ch[0] = 0; m_ch[1] = 0;
    end else begin
      int mask, data, ncnt, nmode;
      bit evt, nen, clr;
      bit [1:0] nrole;
      mask = bwr ? 255 : (bbit ? (1 << bsel) : 0);
      data = bwr ? int'(wdata[7:0]) : (bval ? 255 : 0);
      evt = m_en && tick && m_cnt == int'(MAXV) && (m_mode == 1 || m_mode == 2);
      for (int k = 0; k < 2; k++) begin
        bit capr;
        capr = (m_mode == 1) && m_role[k];
        m_match[k] = m_en && !capr && tick && (m_cnt == m_ch[k]);
        if (m_en && capr && cap[k] && !m_prev[k]) m_ch[k] = m_cnt;
        else if (bwr && addr == 8 + 2 * k) m_ch[k] = int'(wdata);
        m_prev[k] = cap[k];
      end
      nen = m_en; nmode = m_mode; nrole = m_role; clr = 0;
      if (addr == 0 && mask != 0) begin
        if (mask[7]) nen = data[7];
        for (int i = 0; i < 3; i++)
          if (mask[i]) nmode = data[i] ? (nmode | (1 << i)) : (nmode & ~(1 << i));
      end
      if (addr == 5 && mask != 0) begin
        for (int k = 0; k < 2; k++)
          if (mask[4 + k] && (!m_en || data[4 + k] == m_role[k])) nrole[k] = data[4 + k];
        clr = mask[0] && !data[0];
      end
      ncnt = !m_en ? 0 : (tick ? ((m_cnt + 1) % (1 << W)) : m_cnt);
      m_irq = evt;
      if (!m_en) m_ovf = 0;
      else if (evt) m_ovf = 1;
      else if (clr) m_ovf = 0;
      m_cnt = ncnt; m_en = nen; m_mode = nmode; m_role = nrole;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 match_o", match, m_match);
      check("R3 ovf_irq_o", irq, m_irq);
      check(addr == 5 ? "R4 opt read" : (addr == 2 ? "R2 count" : "R9 reg read"),
            rdata, mrd(addr));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic wr(int a, int d);
    step(); bwr = 1; addr = 4'(a); wdata = W'(d);
    step(); bwr = 0;
  endtask
  task automatic bwrite(int a, int s, bit v);
    step(); bbit = 1; addr = 4'(a); bsel = 3'(s); bval = v;
    step(); bbit = 0;
  endtask
  task automatic rd(int a, output int v);
    addr = 4'(a); @(negedge clk); v = int'(rdata);
  endtask
  task automatic wait_irq(string tag);
    int n = 0;
    addr = 4'd5;
    do begin @(negedge clk); n++; end while (!irq && n < 2000);
    check(tag, irq, 1);
  endtask

  initial begin
    int v, c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(0, v); check("R1 ctrl", v, 0);
    rd(2, v); check("R1 count", v, 0);
    rd(5, v); check("R1 opt", v, 0);
    rd(8, v); check("R1 ch0", v, 0);
    rd(10, v); check("R1 ch1", v, 0);
    check("R1 outputs", {match, irq}, 0);

    wr(5, 8'hFF); rd(5, v); check("R6 reserved", v, 8'h30);
    check("R5 write one", v & 1, 0);
    wr(5, 0); rd(5, v); check("R6 cleared", v, 0);

    wr(8, 8'h10);
    wr(0, 8'h81); tick_div = 1;
    addr = 4'd2; c = 0;
    do begin @(negedge clk); c++; end while (!match[0] && c < 600);
    check("R10 match seen", match[0], 1);
    check("R10 count after match", rdata, 8'h11);

    wait_irq("R3 overflow");
    check("R3 flag with irq", rdata, 8'h01);
    @(negedge clk); check("R3 single pulse", irq, 0);

    bwrite(5, 0, 1); rd(5, v); check("R5 write one", v & 1, 1);
    rd(5, v); check("R5 reread", v & 1, 1);
    bwrite(5, 0, 0); rd(5, v); check("R4 bit clear", v & 1, 0);

    wr(5, 8'h10); rd(5, v); check("R7 locked", v & 8'h30, 0);

    wait_irq("R4 overflow again");
    wr(0, 8'h01); step();
    rd(5, v); check("R4 disable clears", v, 0);
    rd(2, v); check("R2 disabled zero", v, 0);

    wr(5, 8'h10); rd(5, v); check("R7 disabled write", v, 8'h10);
    wr(0, 8'h81);
    wr(5, 8'h10); rd(5, v); check("R7 same value", v, 8'h10);
    bwrite(5, 5, 1); rd(5, v); check("R7 diff bit", v & 8'h30, 8'h10);
    bwrite(5, 4, 0); rd(5, v); check("R7 diff bit0", v & 8'h30, 8'h10);

    tick_div = 0; step(); step();
    rd(2, c);
    step(); cap[0] = 1; step(); step(); step(); cap[0] = 0;
    rd(8, v); check("R9 capture", v, c);
    tick_div = 1; repeat (10) step(); tick_div = 0; step(); step();
    rd(8, v); check("R9 single capture", v, c);
    rd(2, c);
    step(); cap[0] = 1; step(); cap[0] = 0;
    rd(8, v); check("R9 second capture", v, c);

    tick_div = 3; repeat (300) step();

    wr(0, 0); wr(8, 8'h20); wr(0, 8'h80); tick_div = 0;
    step(); cap[0] = 1; step(); cap[0] = 0; step();
    rd(8, v); check("R8 no capture outside free-run", v, 8'h20);
    tick_div = 1; addr = 4'd2; c = 0;
    do begin @(negedge clk); c++; end while (!match[0] && c < 600);
    check("R8 compare role", match[0], 1);

    wr(0, 8'h85); c = 0;
    repeat (600) begin @(negedge clk); if (irq) c++; end
    check("R3 no irq in other mode", c, 0);
    rd(5, v); check("R3 no flag in other mode", v & 1, 0);

    wr(0, 8'h81);
    c = 0;
    do begin step(); c++; end while (m_cnt != int'(MAXV) && c < 600);
    bwr = 1; addr = 4'd5; wdata = W'(8'h10);
    step(); bwr = 0;
    rd(5, v); check("R11 overflow wins", v, 8'h11);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    done = 1;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule